// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a processor's activity line and reports when that activity stops. Software toggles the kick line now and then. A rising or a falling change both count as a kick, and each one starts a full countdown of `TIMEOUT_CYC` clock cycles. If the countdown ends before another change arrives, the active-low output `wdo_n_o` drops. It stays low until the next kick. The output can be wired back to the manual-reset input of the system reset generator, so that a stalled program ends in a reset.

Three conditions hold the countdown cleared and idle: the block reset, the system reset being asserted, and `kick_en_i` being low. A low `kick_en_i` stands for a kick pin that is floating or tri-stated. After any of these, counting starts again only at the next kick change. An undervoltage indication drives the output low for as long as it lasts, with no minimum low time. This override does not disturb the countdown. The kick line goes through a synchronizer of `SYNC_STAGES` flops before changes are detected.

Top module: `edge_kick_watchdog`

## Requirements
- R1: After the block reset `rst` is released, `wdo_n_o` is high. With no change ever seen on `kick_i`, it stays high for any length of time.
- R2: With the default two synchronizer stages, a change of `kick_i` set up before clock edge n drives `wdo_n_o` low after edge n+TIMEOUT_CYC+3, provided nothing else changes. It is still high after edge n+TIMEOUT_CYC+2.
- R3: A rising and a falling change of `kick_i` act alike. Each restarts a full countdown, so kicks spaced by fewer than TIMEOUT_CYC cycles keep `wdo_n_o` high. A kick that arrives in the same cycle the countdown would end takes priority over the expiry.
- R4: Once the timer has expired, `wdo_n_o` stays low for any length of time until a change of `kick_i` arrives. For a change before edge n, the output is still low after edge n+2 and high after edge n+3.
- R5: While `kick_en_i` is low, the countdown is cleared and does not run. The expired state is also cleared, so `wdo_n_o` is high from the second edge after `kick_en_i` falls, given a good supply. After `kick_en_i` returns high, the timer stays idle until the next change.
- R6: While `sys_rst_i` is high, the countdown is cleared and disabled in the same way as in R5. After `sys_rst_i` is released, counting begins only at the first change of `kick_i`.
- R7: Whenever `supply_ok_i` is low at a clock edge, `wdo_n_o` is low after that edge. If the timer has not expired, the output is high after the first edge at which the supply is good again. A dip of one cycle gives a low output of exactly one cycle.
- R8: An undervoltage period does not restart, clear or pause the countdown. Expiry happens at the same cycle it would have without the dip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset (power-up) |
| kick_i | input | 1 | Activity line from the processor; either edge is a kick |
| kick_en_i | input | 1 | High when the kick pin is driven; low models a floating pin |
| sys_rst_i | input | 1 | High while the system reset is asserted |
| supply_ok_i | input | 1 | High while the supply is above its threshold |
| wdo_n_o | output | 1 | Registered active-low watchdog output |

## Verification
Two events can meet in one cycle: a kick restart and the end of the countdown. The bench places a kick so that its detected change lands in exactly the cycle the count reaches its limit. It then checks that the output never drops. It also places a kick one cycle later, where the output must fall for a single cycle. A third case overlays an undervoltage dip on a running countdown and on an expired one. The per-cycle reference model decides in each case whether the override, the expiry or the restart is visible at the output.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q[0] <= 1'b0;
    else     sh_q[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh_q[g] <= 1'b0;
        else     sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[STAGES-1];
  end

  assign edge_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  wd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (hold) begin
      st_q  <= WD_IDLE;
      cnt_q <= '0;
    end else if (kick) begin
      st_q  <= WD_RUN;
      cnt_q <= '0;
    end else if (st_q == WD_RUN) begin
      if (cnt_q == LAST) st_q <= WD_TRIP;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (st_q == WD_TRIP);
endmodule

// File: rtl/wdg_outreg.sv
module wdg_outreg (
  input  logic clk,
  input  logic rst,
  input  logic expired,
  input  logic supply_ok,
  output logic out_n
);
  always_ff @(posedge clk) begin
    if (rst) out_n <= 1'b1;
    else     out_n <= supply_ok & ~expired;
  end
endmodule

// File: rtl/edge_kick_watchdog.sv
module edge_kick_watchdog #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic kick_en_i,
  input  logic sys_rst_i,
  input  logic supply_ok_i,
  output logic wdo_n_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             kick_edge;
  logic             hold;
  logic             expired;
  logic [CNT_W-1:0] cnt;

  assign hold = rst | sys_rst_i | ~kick_en_i;

  wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (kick_i),
    .edge_o (kick_edge)
  );

  wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .hold      (hold),
    .kick      (kick_edge),
    .cnt_o     (cnt),
    .expired_o (expired)
  );

  wdg_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .expired   (expired),
    .supply_ok (supply_ok_i),
    .out_n     (wdo_n_o)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int CNT_W       = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             kick_en_i,
  input logic             sys_rst_i,
  input logic             supply_ok_i,
  input logic             wdo_n_o,
  input logic             kick_edge,
  input logic             expired,
  input logic [CNT_W-1:0] cnt
);
  logic hold_c;
  assign hold_c = sys_rst_i | ~kick_en_i;

  p_uv_forces_low_r7: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !wdo_n_o);

  p_enable_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (!kick_en_i ##1 supply_ok_i) |=> wdo_n_o);

  p_sysrst_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_i ##1 supply_ok_i) |=> wdo_n_o);

  p_trip_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (expired && !kick_edge && !hold_c) |=> expired);

  p_kick_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    (kick_edge && !hold_c) |=> !expired);

  p_fall_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n_o) |-> ($past(expired) || !$past(supply_ok_i)));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(TIMEOUT_CYC - 1));
endmodule

bind edge_kick_watchdog wdg_checker #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .kick_en_i   (kick_en_i),
  .sys_rst_i   (sys_rst_i),
  .supply_ok_i (supply_ok_i),
  .wdo_n_o     (wdo_n_o),
  .kick_edge   (kick_edge),
  .expired     (expired),
  .cnt         (cnt)
);

// File: tb/sim_edge_kick_watchdog.sv
module sim_edge_kick_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0;
  logic en = 1'b1;
  logic srst = 1'b0;
  logic sup = 1'b1;
  logic wdo_n;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_kick_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .kick_i(kick), .kick_en_i(en),
    .sys_rst_i(srst), .supply_ok_i(sup), .wdo_n_o(wdo_n)
  );

  // behavioural reference: elapsed cycles since last detected kick
  int  q_kick[$];
  int  last_seen = 0;
  bit  active = 1'b0;
  int  elapsed = 0;
  bit  ref_wdo_n = 1'b1;

  always @(posedge clk) begin
    bit tripped;
    bit changed;
    tripped = active && (elapsed >= T);
    changed = (q_kick.size() == 2) && (q_kick[0] != last_seen);
    if (rst) begin
      ref_wdo_n = 1'b1;
      q_kick = {};
      last_seen = 0;
      active = 1'b0;
      elapsed = 0;
    end else begin
      ref_wdo_n = sup && !tripped;
      if (srst || !en) begin
        active = 1'b0;
        elapsed = 0;
      end else if (changed) begin
        active = 1'b1;
        elapsed = 0;
      end else if (active && elapsed < T) begin
        elapsed++;
      end
      if (q_kick.size() == 2) begin
        last_seen = q_kick[0];
        void'(q_kick.pop_front());
      end else begin
        last_seen = 0;
      end
      q_kick.push_back(int'(kick));
    end
  end

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) check(phase, wdo_n, ref_wdo_n);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    kick = ~kick;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    check("R1 reset state", wdo_n, 1'b1);
    step(80);
    check("R1 idle stays high", wdo_n, 1'b1);

    phase = "R2";
    toggle();
    step(T + 3);
    check("R2 high at n+T+2", wdo_n, 1'b1);
    step(1);
    check("R2 low at n+T+3", wdo_n, 1'b0);

    phase = "R4";
    step(40);
    check("R4 stays low", wdo_n, 1'b0);
    toggle();
    step(3);
    check("R4 low at n+2", wdo_n, 1'b0);
    step(1);
    check("R4 high at n+3", wdo_n, 1'b1);

    phase = "R3";
    for (int i = 0; i < 6; i++) begin
      step(T - 5);
      toggle();
    end
    step(T);
    toggle();
    step(12);
    check("R3 same-cycle kick wins", wdo_n, 1'b1);
    step(T - 12 + 1);
    toggle();
    step(8);
    check("R3 late kick recovers", wdo_n, 1'b1);

    phase = "R5";
    step(T + 10);
    check("R5 expired before disable", wdo_n, 1'b0);
    en = 1'b0;
    step(2);
    check("R5 high after disable", wdo_n, 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(7);
      toggle();
    end
    step(T + 20);
    check("R5 no count while floating", wdo_n, 1'b1);
    en = 1'b1;
    step(T + 30);
    check("R5 idle after enable", wdo_n, 1'b1);
    toggle();
    step(T + 4);
    check("R5 counts after kick", wdo_n, 1'b0);

    phase = "R6";
    srst = 1'b1;
    step(2);
    check("R6 high in system reset", wdo_n, 1'b1);
    toggle();
    step(T + 20);
    check("R6 no count in system reset", wdo_n, 1'b1);
    srst = 1'b0;
    step(T + 30);
    check("R6 idle after release", wdo_n, 1'b1);
    toggle();
    step(T + 4);
    check("R6 counts after kick", wdo_n, 1'b0);

    phase = "R7";
    toggle();
    step(6);
    sup = 1'b0;
    step(1);
    check("R7 low during dip", wdo_n, 1'b0);
    sup = 1'b1;
    step(1);
    check("R7 high right after dip", wdo_n, 1'b1);

    phase = "R8";
    toggle();
    step(4);
    sup = 1'b0;
    step(10);
    check("R8 low during long dip", wdo_n, 1'b0);
    sup = 1'b1;
    step(T + 3 - 14);
    check("R8 high before expiry", wdo_n, 1'b1);
    step(1);
    check("R8 expiry time unchanged", wdo_n, 1'b0);
    sup = 1'b0;
    step(3);
    sup = 1'b1;
    step(3);
    check("R7 expired stays low after dip", wdo_n, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule